// File: doc/BRIEF.md
# Multiphase Memory Test Sequencer

This block drives one memory operation per start pulse for a small memory test rig. A start pulse received while the block is idle sets the first of four phase flops. The flops then shift one place each clock. The four phases switch on one at a time and then switch off one at a time, so every operation spans seven clock periods. Each period is identified by two adjacent phases. Simple decodes of the phases produce the memory chip select, the write strobe, the read-data capture strobe, the switch-buffer enable and the address-step pulse.

A write/read mode input picks the kind of pass. In a fill pass each operation stores switch data at the current address. In a view pass each operation captures the stored word into an output register. The address counter moves forward by one after each operation, so repeated start pulses walk through the memory. The memory itself and any display logic sit outside this block.

Top module: `mem_phase_sequencer`

## Requirements
- R1: A start pulse seen at a clock edge while all phases are 0 loads the phase vector `phase` with 1000 (bit 3 is F1, bit 0 is F4). On the following edges the vector steps through 1100, 1110, 1111, 0111, 0011 and 0001, which are periods 1 to 7. It then returns to 0000 and stays there until the next start.
- R2: `cs_n` is low exactly in periods 2 to 5, which is while F2 is high. It is high in every other state.
- R3: In write mode (`wr_mode` = 1 at start) `we_n` is low exactly in periods 3 and 4, where F1 and F3 are both high. In read mode `we_n` stays high for the whole operation.
- R4: The `we_n` low pulse lies strictly inside the `cs_n` low pulse: `cs_n` falls at least one clock before `we_n` falls and rises at least one clock after `we_n` rises.
- R5: `latch_n` is low only in period 5 (F1 low, F2 high), in both modes.
- R6: In write mode `buf_en_n` is low for exactly the cycles in which `cs_n` is low. In read mode it stays high.
- R7: `addr_inc` is high only in period 7 (only F4 high). `addr` goes up by one at the end of that period, so the new value shows in the first idle cycle. It wraps from all ones to 0.
- R8: A start pulse that arrives while an operation is running does not change the phase sequence or the address. No extra operation follows from it.
- R9: The mode is taken when the start is accepted. A change of `wr_mode` during an operation has no effect on `we_n` or `buf_en_n` for that operation.
- R10: An active-low asynchronous `rst_n` clears `addr` to 0 and the phases to 0000, and drives every strobe to its inactive level, even in the middle of an operation.
- R11: `busy` is high exactly while any phase is high. Back-to-back operations always have at least one idle cycle between them, even if `start` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-clock start request from the debounced button |
| wr_mode | input | 1 | 1 selects a fill (write) pass, 0 a view (read) pass |
| cs_n | output | 1 | Memory chip select, active low |
| we_n | output | 1 | Memory write strobe, active low |
| latch_n | output | 1 | Output register capture strobe, active low |
| buf_en_n | output | 1 | Switch-to-bus buffer enable, active low |
| addr_inc | output | 1 | Address-step pulse |
| addr | output | ADDR_W | Current memory address |
| busy | output | 1 | Operation in progress |
| phase | output | 4 | Phase vector, bit 3 = F1 down to bit 0 = F4 |

## Verification
The bench checks the strobe nesting edge by edge. A decode that used the wrong phase pair would let `we_n` fall in the same cycle as `cs_n`, or rise after it. A start pulse injected in mid-operation catches a design that reloads the first phase, which would restart the sequence and step the address twice. The bench also flips the mode during a read, which exposes a design that decodes the live mode input and would raise a stray write strobe. Holding `start` high across the end of an operation, running the counter through its wrap, and resetting in the middle of a write show whether the idle gap, the modular step and the asynchronous clear are right.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  localparam int PHASES  = 4;
  localparam int PERIODS = 2 * PHASES - 1;

  // bit PHASES-1 is F1, bit 0 is F(PHASES)
  typedef logic [PHASES-1:0] phase_t;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic latch_n;
    logic buf_en_n;
    logic addr_inc;
  } strobe_t;

  // Value of phase Fk (k counts from 1)
  function automatic logic ph(input phase_t p, input int k);
    return p[PHASES-k];
  endfunction

  // One right shift; the serial input is the complement of the last phase
  function automatic phase_t phase_next(input phase_t p);
    return {~p[0], p[PHASES-1:1]};
  endfunction

  // First period pattern: only F1 set
  function automatic phase_t phase_first();
    phase_t r;
    r = '0;
    r[PHASES-1] = 1'b1;
    return r;
  endfunction

  // Rising half: period k is Fk high and F(k+1) low; the last one is F1 and F(PHASES)
  // Falling half: period PHASES+j is Fj low and F(j+1) high
  function automatic logic in_period(input phase_t p, input int n);
    if (n < PHASES)
      return ph(p, n) & ~ph(p, n + 1);
    else if (n == PHASES)
      return ph(p, 1) & ph(p, PHASES);
    else
      return ~ph(p, n - PHASES) & ph(p, n - PHASES + 1);
  endfunction

endpackage

// File: rtl/mseq_phase_shifter.sv
module mseq_phase_shifter
  import mseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_t phase,
  output logic   idle,
  output logic   accept
);

  assign idle   = (phase == '0);
  assign accept = start & idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= '0;
    else if (accept)
      phase <= phase_first();
    else if (!idle)
      phase <= phase_next(phase);
  end

endmodule

// File: rtl/mseq_strobe_decode.sv
module mseq_strobe_decode
  import mseq_pkg::*;
(
  input  phase_t               phase,
  input  logic                 wr_sel,
  output logic [PERIODS-1:0]   period_hot,
  output strobe_t              strobe
);

  genvar n;
  generate
    for (n = 1; n <= PERIODS; n++) begin : g_period
      assign period_hot[n-1] = in_period(phase, n);
    end
  endgenerate

  logic sel_on;
  logic wr_on;

  assign sel_on = ph(phase, 2);
  assign wr_on  = ph(phase, 1) & ph(phase, 3) & wr_sel;

  always_comb begin
    strobe.cs_n     = ~sel_on;
    strobe.we_n     = ~wr_on;
    strobe.latch_n  = ~period_hot[PHASES];      // period PHASES+1
    strobe.buf_en_n = ~(sel_on & wr_sel);
    strobe.addr_inc = period_hot[PERIODS-1];    // last period
  end

endmodule

// File: rtl/mseq_addr_counter.sv
module mseq_addr_counter #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addr <= '0;
    else if (step)
      addr <= addr + ONE;
  end

endmodule

// File: rtl/mem_phase_sequencer.sv
module mem_phase_sequencer
  import mseq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_mode,
  output logic              cs_n,
  output logic              we_n,
  output logic              latch_n,
  output logic              buf_en_n,
  output logic              addr_inc,
  output logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic [3:0]        phase
);

  phase_t             phase_q;
  logic               idle;
  logic               start_ok;
  logic               wr_mode_q;
  logic [PERIODS-1:0] period_hot;
  strobe_t            strb;

  mseq_phase_shifter u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .phase  (phase_q),
    .idle   (idle),
    .accept (start_ok)
  );

  // mode is captured with the start so a later change cannot disturb the operation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wr_mode_q <= 1'b0;
    else if (start_ok)
      wr_mode_q <= wr_mode;
  end

  mseq_strobe_decode u_dec (
    .phase      (phase_q),
    .wr_sel     (wr_mode_q),
    .period_hot (period_hot),
    .strobe     (strb)
  );

  mseq_addr_counter #(.ADDR_W(ADDR_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (strb.addr_inc),
    .addr  (addr)
  );

  assign cs_n     = strb.cs_n;
  assign we_n     = strb.we_n;
  assign latch_n  = strb.latch_n;
  assign buf_en_n = strb.buf_en_n;
  assign addr_inc = strb.addr_inc;
  assign busy     = ~idle;
  assign phase    = phase_q;

endmodule

// File: rtl/mseq_checker.sv
module mseq_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic [3:0]        phase,
  input logic              cs_n,
  input logic              we_n,
  input logic              latch_n,
  input logic              addr_inc,
  input logic [ADDR_W-1:0] addr,
  input logic              mode_q
);

  // R1
  seq_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase != 4'b0001) |=> busy);

  // R1
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

  // R4
  we_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cs_n);

  // R4
  we_fall_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $past(!cs_n));

  // R4
  we_rise_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> !cs_n);

  // R5
  latch_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_n) |-> $rose(cs_n));

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_inc |=> addr == ADDR_W'($past(addr) + 1'b1));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_inc |=> $stable(addr));

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> phase != 4'b1000);

  // R9
  mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_q));

  // R3
  read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> we_n);

endmodule

bind mem_phase_sequencer mseq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .phase    (phase),
  .cs_n     (cs_n),
  .we_n     (we_n),
  .latch_n  (latch_n),
  .addr_inc (addr_inc),
  .addr     (addr),
  .mode_q   (wr_mode_q)
);

// File: tb/mem_phase_sequencer_bench.sv
module mem_phase_sequencer_bench;

  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic          wr_mode;
  logic          cs_n, we_n, latch_n, buf_en_n, addr_inc, busy;
  logic [AW-1:0] addr;
  logic [3:0]    phase;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mem_phase_sequencer #(.ADDR_W(AW)) u_mem_phase_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_mode(wr_mode),
    .cs_n(cs_n), .we_n(we_n), .latch_n(latch_n), .buf_en_n(buf_en_n),
    .addr_inc(addr_inc), .addr(addr), .busy(busy), .phase(phase)
  );

  // {mode, step[2:0], phase[3:0], cs_n, we_n, latch_n, buf_en_n, addr_inc}
  localparam int NV = 14;
  localparam logic [12:0] VEC [NV] = '{
    13'b1_001_1000_11110,
    13'b1_010_1100_01100,
    13'b1_011_1110_00100,
    13'b1_100_1111_00100,
    13'b1_101_0111_01000,
    13'b1_110_0011_11110,
    13'b1_111_0001_11111,
    13'b0_001_1000_11110,
    13'b0_010_1100_01110,
    13'b0_011_1110_01110,
    13'b0_100_1111_01110,
    13'b0_101_0111_01010,
    13'b0_110_0011_11110,
    13'b0_111_0001_11111
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic m);
    start   = 1'b1;
    wr_mode = m;
    tick();
    start = 1'b0;
    repeat (7) tick();
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    start   = 1'b0;
    wr_mode = 1'b0;
    repeat (3) tick();
    // R10 reset state
    check({phase, cs_n, we_n, latch_n, buf_en_n, addr_inc, busy, addr} ==
          {4'b0000, 4'b1111, 1'b0, 1'b0, AW'(0)}, "R10 reset state",
          {phase, cs_n, we_n, latch_n, buf_en_n, addr_inc, busy, addr},
          {4'b0000, 4'b1111, 1'b0, 1'b0, AW'(0)});
    rst_n = 1'b1;
    tick();

    // table walk: R1 R2 R3 R5 R6 R7 R11
    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      logic [9:0]  got, exp;
      v = VEC[i];
      if (v[11:9] == 3'd1) begin
        if (i != 0) begin
          tick();
          check(addr == AW'(1) && !busy, "R7 addr after fill", {busy, addr}, {1'b0, AW'(1)});
        end
        start   = 1'b1;
        wr_mode = v[12];
      end
      tick();
      start = 1'b0;
      got = {phase, cs_n, we_n, latch_n, buf_en_n, addr_inc, busy};
      exp = {v[8:0], 1'b1};
      check(got == exp, "R1/R2/R3/R5/R6/R7/R11 table", got, exp);
    end
    tick();
    check(addr == AW'(2) && phase == 4'b0000 && !busy, "R1 R11 idle after view",
          {busy, phase, addr}, {1'b0, 4'b0000, AW'(2)});

    // R8: start during a running operation
    start = 1'b1; wr_mode = 1'b1;
    tick();
    start = 1'b0;
    tick();                       // period 2
    start = 1'b1;
    tick();
    start = 1'b0;
    check(phase == 4'b1110, "R8 sequence unchanged", phase, 4'b1110);
    repeat (4) tick();            // periods 4..7
    check(addr_inc == 1'b1, "R7 step pulse in period 7", addr_inc, 1'b1);
    tick();
    check(addr == AW'(3) && !busy, "R8 single step", {busy, addr}, {1'b0, AW'(3)});
    tick();
    check(!busy, "R8 no extra operation", busy, 1'b0);

    // R9: mode change during a read
    start = 1'b1; wr_mode = 1'b0;
    tick();
    start = 1'b0; wr_mode = 1'b1;
    tick(); tick();               // period 3
    check(we_n == 1'b1 && buf_en_n == 1'b1, "R9 mode held", {we_n, buf_en_n}, 2'b11);
    repeat (5) tick();
    check(addr == AW'(4), "R9 addr", addr, AW'(4));

    // R11: start held high across the end of an operation
    start = 1'b1; wr_mode = 1'b1;
    repeat (7) tick();            // period 7
    check(phase == 4'b0001, "R11 last period", phase, 4'b0001);
    tick();
    check(!busy && phase == 4'b0000, "R11 idle gap", {busy, phase}, 5'b0_0000);
    tick();
    check(phase == 4'b1000, "R1 restart from idle", phase, 4'b1000);
    start = 1'b0;
    repeat (7) tick();
    check(addr == AW'(6), "R7 two steps", addr, AW'(6));

    // R7 wrap
    repeat (9) run_op(1'b0);
    check(addr == AW'(15), "R7 top value", addr, AW'(15));
    run_op(1'b0);
    check(addr == AW'(0), "R7 wrap to zero", addr, AW'(0));

    // R10: reset during a write
    run_op(1'b1);
    start = 1'b1; wr_mode = 1'b1;
    tick();
    start = 1'b0;
    tick(); tick();               // period 3, write strobe low
    rst_n = 1'b0;
    #1;
    check({phase, cs_n, we_n, latch_n, buf_en_n, addr_inc, addr} ==
          {4'b0000, 4'b1111, 1'b0, AW'(0)}, "R10 mid-run reset",
          {phase, cs_n, we_n, latch_n, buf_en_n, addr_inc, addr},
          {4'b0000, 4'b1111, 1'b0, AW'(0)});
    tick();
    rst_n = 1'b1;
    tick();
    check(!busy, "R10 stays idle after reset", busy, 1'b0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule